// File: doc/BRIEF.md
# UTOPIA Level 2 Addressed Slave Cell Port

This block is a slave endpoint on a shared multi-PHY cell bus. Up to 31 devices share one address bus; the master polls each one in turn. The port reacts only when the polled address equals its own programmed address. It then reports whether it can take a cell (downstream, master to slave) or has a cell to give (upstream, slave to master). Handshaking is per cell. Once the master enables a transfer, the whole cell moves on consecutive clocks.

The data bus is 8 or 16 bits wide, chosen at build time. Every word the port drives carries odd parity. Every word it samples is checked against odd parity. Each direction holds exactly one cell.

The cell length is programmed in bytes, up to 64, so that an optional routing tag word can lead the cell. On the upstream side the port inserts the tag word ahead of the payload. On the downstream side it strips the first word before handing the cell to the core. The first word of a cell is marked with a start flag. A downstream cell that arrives without that flag on its first word is thrown away and counted.

Top module: `utl2_slave_port`

## Requirements
- R1: Address 31 is the idle address and never selects the port, even when it is programmed as the port's own address. In a cycle where bus_addr does not select the port, both cell-available outputs are low one clock later. Whenever up_oe is low, up_data, up_par and up_soc are all 0.
- R2: A cell-available output is high in the clock after a cycle in which bus_addr selected the port, if the matching buffer can act. For up_clav that means a complete cell is held. For dn_clav that means the buffer is empty.
- R3: If up_en is sampled high while the port is selected and up_clav is high, the upstream cell is driven starting in the next clock. It uses consecutive clocks with up_oe high. up_soc is high on the first word only.
- R4: Every driven upstream word has up_par set so that up_data plus up_par hold an odd number of ones.
- R5: With cfg_tag_en set, the first upstream word is cfg_tag, followed by the payload words in the order the core supplied them.
- R6: If dn_en is sampled high while the port is selected and dn_clav is high, dn_data is sampled for one cell on the consecutive clocks that follow. The cell is then offered to the core in order, with core_dn_last on the final payload word.
- R7: With cfg_tag_en set, the first downstream word is discarded and is not given to the core.
- R8: A downstream cell whose first word has dn_soc low is not given to the core. In that case dn_drop_cnt rises by exactly 1, saturating at its maximum, and the buffer stays free for the next cell.
- R9: A delivered downstream cell shows core_dn_perr high on all its words if any word of the cell had odd-parity violated. Otherwise core_dn_perr is low.
- R10: up_clav is low while a cell is being driven and after its last word. It stays low until the core has refilled a whole cell. dn_clav stays low from the start of a capture until the core has taken the last word.
- R11: During and right after reset, up_clav, dn_clav, up_oe, core_dn_valid and dn_drop_cnt are 0, and core_up_ready is 1.
- R12: A cell is cfg_cell_bytes divided by DATA_W/8 words long, tag word included. The core supplies or receives that count minus the tag word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 5 | Programmed slave address |
| cfg_cell_bytes | input | $clog2(MAX_BYTES+1) | Cell length in bytes, tag included |
| cfg_tag_en | input | 1 | Routing tag word present |
| cfg_tag | input | DATA_W | Tag word inserted upstream |
| bus_addr | input | 5 | Address driven by the master |
| up_en | input | 1 | Master enable, upstream transfer |
| up_clav | output | 1 | Upstream cell available |
| up_oe | output | 1 | Upstream data valid and driven |
| up_data | output | DATA_W | Upstream data word |
| up_par | output | 1 | Odd parity of up_data |
| up_soc | output | 1 | Start-of-cell flag upstream |
| dn_en | input | 1 | Master enable, downstream transfer |
| dn_data | input | DATA_W | Downstream data word |
| dn_par | input | 1 | Odd parity of dn_data |
| dn_soc | input | 1 | Start-of-cell flag downstream |
| dn_clav | output | 1 | Room for one downstream cell |
| core_up_valid | input | 1 | Core offers an upstream payload word |
| core_up_data | input | DATA_W | Upstream payload word |
| core_up_ready | output | 1 | Port accepts the word |
| core_dn_valid | output | 1 | Downstream word available to core |
| core_dn_data | output | DATA_W | Downstream payload word |
| core_dn_last | output | 1 | Last payload word of the cell |
| core_dn_perr | output | 1 | Cell had a parity error |
| core_dn_ready | input | 1 | Core takes the word |
| dn_drop_cnt | output | CNT_W | Cells dropped for missing start flag |

## Verification
Cell transfers are run in both directions with random payloads, random cell lengths from 2 to 32 words, and the tag option random. Comparing word order, start flag and parity against the bench's own model shows whether the word count and tag handling follow the programmed length. Directed cells then probe four things: a foreign address with enable raised must leave the held cell untouched; address 31 programmed as the port's own must never select it; a first word without the start flag must separate a drop from a delivery; and a single flipped parity bit must mark the cell without losing it. Polling again after each transfer tells a freed buffer from one still held.

// File: rtl/utl2_pkg.sv
`timescale 1ns/1ps
package utl2_pkg;
    localparam int unsigned ADDR_W = 5;
    localparam logic [ADDR_W-1:0] IDLE_ADDR = 5'd31;

    // parity bit that makes the word plus the bit hold an odd number of ones
    function automatic logic odd_par(input logic [31:0] w);
        return ~(^w);
    endfunction
endpackage

// File: rtl/utl2_addr_match.sv
`timescale 1ns/1ps
module utl2_addr_match
    import utl2_pkg::*;
(
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] cfg_addr,
    output logic              hit
);
    // idle address can never be claimed
    assign hit = (bus_addr == cfg_addr) && (cfg_addr != IDLE_ADDR);
endmodule

// File: rtl/utl2_cell_len.sv
`timescale 1ns/1ps
module utl2_cell_len #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 7,
    parameter int IDX_W  = 6
) (
    input  logic [BYTE_W-1:0] cell_bytes,
    input  logic              tag_en,
    output logic [IDX_W-1:0]  cell_words,
    output logic [IDX_W-1:0]  pay_words
);
    localparam int SH = (DATA_W == 16) ? 1 : 0;
    logic [BYTE_W-1:0] words_full;

    assign words_full = cell_bytes >> SH;
    assign cell_words = IDX_W'(words_full);
    assign pay_words  = cell_words - IDX_W'(tag_en);
endmodule

// File: rtl/utl2_up_path.sv
`timescale 1ns/1ps
module utl2_up_path
    import utl2_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  cell_words,
    input  logic [IDX_W-1:0]  pay_words,
    input  logic              tag_en,
    input  logic [DATA_W-1:0] tag_word,
    input  logic              hit,
    input  logic              bus_en,
    input  logic              core_valid,
    input  logic [DATA_W-1:0] core_data,
    output logic              core_ready,
    output logic              clav,
    output logic              oe,
    output logic [DATA_W-1:0] data,
    output logic              par,
    output logic              soc
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    typedef struct packed {
        logic              full;
        logic              busy;
        logic [IDX_W-1:0]  fill;
        logic [IDX_W-1:0]  idx;
        logic              clav;
        logic              oe;
        logic              soc;
        logic              par;
        logic [DATA_W-1:0] data;
    } up_state_t;

    up_state_t s_q, s_d;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              wr_en;
    logic [IDX_W-1:0]  wr_addr;
    logic              start;
    logic [IDX_W-1:0]  send_idx;
    logic [IDX_W-1:0]  rd_addr;
    logic [DATA_W-1:0] send_word;

    always_comb begin
        s_d        = s_q;
        core_ready = !s_q.full && !s_q.busy;
        wr_en      = 1'b0;
        wr_addr    = s_q.fill;
        start      = bus_en && hit && s_q.full && !s_q.busy;

        // filling from the core
        if (core_ready && core_valid) begin
            wr_en = 1'b1;
            if (s_q.fill == pay_words - ONE) begin
                s_d.full = 1'b1;
                s_d.fill = '0;
            end else begin
                s_d.fill = s_q.fill + ONE;
            end
        end

        // word selection: tag first when enabled
        send_idx  = start ? '0 : s_q.idx;
        rd_addr   = send_idx - IDX_W'(tag_en);
        send_word = (tag_en && (send_idx == '0)) ? tag_word : mem[rd_addr];

        s_d.oe   = 1'b0;
        s_d.soc  = 1'b0;
        s_d.par  = 1'b0;
        s_d.data = '0;

        if (start) begin
            s_d.busy = 1'b1;
            s_d.idx  = ONE;
            s_d.oe   = 1'b1;
            s_d.soc  = 1'b1;
            s_d.data = send_word;
            s_d.par  = odd_par(32'(send_word));
        end else if (s_q.busy) begin
            if (s_q.idx == cell_words) begin
                s_d.busy = 1'b0;
                s_d.full = 1'b0;
                s_d.idx  = '0;
            end else begin
                s_d.idx  = s_q.idx + ONE;
                s_d.oe   = 1'b1;
                s_d.data = send_word;
                s_d.par  = odd_par(32'(send_word));
            end
        end

        s_d.clav = hit && s_d.full && !s_d.busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= core_data;
    end

    assign clav = s_q.clav;
    assign oe   = s_q.oe;
    assign data = s_q.data;
    assign par  = s_q.par;
    assign soc  = s_q.soc;
endmodule

// File: rtl/utl2_dn_path.sv
`timescale 1ns/1ps
module utl2_dn_path
    import utl2_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 6,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  cell_words,
    input  logic [IDX_W-1:0]  pay_words,
    input  logic              tag_en,
    input  logic              hit,
    input  logic              bus_en,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_par,
    input  logic              bus_soc,
    output logic              clav,
    output logic              core_valid,
    output logic [DATA_W-1:0] core_data,
    output logic              core_last,
    output logic              core_perr,
    input  logic              core_ready,
    output logic [CNT_W-1:0]  drop_cnt
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    typedef struct packed {
        logic              busy;
        logic              drop;
        logic              perr;
        logic              full;
        logic              cell_perr;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  rd;
        logic              clav;
        logic [CNT_W-1:0]  drops;
    } dn_state_t;

    dn_state_t s_q, s_d;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              wr_en;
    logic [IDX_W-1:0]  wr_addr;
    logic              start;
    logic              drop_now;
    logic              bad_now;

    always_comb begin
        s_d      = s_q;
        wr_en    = 1'b0;
        wr_addr  = s_q.idx - IDX_W'(tag_en);
        start    = bus_en && hit && !s_q.full && !s_q.busy;
        drop_now = (s_q.idx == '0) ? !bus_soc : s_q.drop;
        bad_now  = s_q.perr || (bus_par != odd_par(32'(bus_data)));

        if (start) begin
            s_d.busy = 1'b1;
            s_d.idx  = '0;
            s_d.drop = 1'b0;
            s_d.perr = 1'b0;
        end else if (s_q.busy) begin
            s_d.drop = drop_now;
            s_d.perr = bad_now;
            wr_en    = !drop_now && !(tag_en && (s_q.idx == '0));
            if (s_q.idx == cell_words - ONE) begin
                s_d.busy = 1'b0;
                s_d.idx  = '0;
                if (drop_now) begin
                    if (s_q.drops != '1) s_d.drops = s_q.drops + CNT_W'(1);
                end else begin
                    s_d.full      = 1'b1;
                    s_d.cell_perr = bad_now;
                    s_d.rd        = '0;
                end
            end else begin
                s_d.idx = s_q.idx + ONE;
            end
        end

        // draining toward the core
        core_valid = s_q.full;
        core_data  = mem[s_q.rd];
        core_last  = s_q.full && (s_q.rd == pay_words - ONE);
        core_perr  = s_q.full && s_q.cell_perr;
        if (s_q.full && core_ready) begin
            if (s_q.rd == pay_words - ONE) begin
                s_d.full = 1'b0;
                s_d.rd   = '0;
            end else begin
                s_d.rd = s_q.rd + ONE;
            end
        end

        s_d.clav = hit && !s_d.full && !s_d.busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= bus_data;
    end

    assign clav     = s_q.clav;
    assign drop_cnt = s_q.drops;
endmodule

// File: rtl/utl2_slave_port.sv
`timescale 1ns/1ps
module utl2_slave_port
    import utl2_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MAX_BYTES = 64,
    parameter int CNT_W     = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [4:0]                     cfg_addr,
    input  logic [$clog2(MAX_BYTES+1)-1:0] cfg_cell_bytes,
    input  logic                           cfg_tag_en,
    input  logic [DATA_W-1:0]              cfg_tag,
    input  logic [4:0]                     bus_addr,
    input  logic                           up_en,
    output logic                           up_clav,
    output logic                           up_oe,
    output logic [DATA_W-1:0]              up_data,
    output logic                           up_par,
    output logic                           up_soc,
    input  logic                           dn_en,
    input  logic [DATA_W-1:0]              dn_data,
    input  logic                           dn_par,
    input  logic                           dn_soc,
    output logic                           dn_clav,
    input  logic                           core_up_valid,
    input  logic [DATA_W-1:0]              core_up_data,
    output logic                           core_up_ready,
    output logic                           core_dn_valid,
    output logic [DATA_W-1:0]              core_dn_data,
    output logic                           core_dn_last,
    output logic                           core_dn_perr,
    input  logic                           core_dn_ready,
    output logic [CNT_W-1:0]               dn_drop_cnt
);
    localparam int BYTE_W    = $clog2(MAX_BYTES + 1);
    localparam int MAX_WORDS = MAX_BYTES / (DATA_W / 8);
    localparam int IDX_W     = $clog2(MAX_WORDS + 1);

    logic             hit;
    logic [IDX_W-1:0] cell_words;
    logic [IDX_W-1:0] pay_words;

    utl2_addr_match i_match (
        .bus_addr (bus_addr),
        .cfg_addr (cfg_addr),
        .hit      (hit)
    );

    utl2_cell_len #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) i_len (
        .cell_bytes (cfg_cell_bytes),
        .tag_en     (cfg_tag_en),
        .cell_words (cell_words),
        .pay_words  (pay_words)
    );

    utl2_up_path #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_up (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_words (cell_words),
        .pay_words  (pay_words),
        .tag_en     (cfg_tag_en),
        .tag_word   (cfg_tag),
        .hit        (hit),
        .bus_en     (up_en),
        .core_valid (core_up_valid),
        .core_data  (core_up_data),
        .core_ready (core_up_ready),
        .clav       (up_clav),
        .oe         (up_oe),
        .data       (up_data),
        .par        (up_par),
        .soc        (up_soc)
    );

    utl2_dn_path #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_dn (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_words (cell_words),
        .pay_words  (pay_words),
        .tag_en     (cfg_tag_en),
        .hit        (hit),
        .bus_en     (dn_en),
        .bus_data   (dn_data),
        .bus_par    (dn_par),
        .bus_soc    (dn_soc),
        .clav       (dn_clav),
        .core_valid (core_dn_valid),
        .core_data  (core_dn_data),
        .core_last  (core_dn_last),
        .core_perr  (core_dn_perr),
        .core_ready (core_dn_ready),
        .drop_cnt   (dn_drop_cnt)
    );
endmodule

// File: rtl/utl2_slave_port_chk.sv
`timescale 1ns/1ps
module utl2_slave_port_chk #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        cfg_addr,
    input logic [4:0]        bus_addr,
    input logic              up_en,
    input logic              up_clav,
    input logic              up_oe,
    input logic [DATA_W-1:0] up_data,
    input logic              up_par,
    input logic              up_soc,
    input logic              dn_clav,
    input logic [CNT_W-1:0]  dn_drop_cnt
);
    logic sel_now;
    assign sel_now = (bus_addr == cfg_addr) && (cfg_addr != 5'd31);

    assert_unselected_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_now |=> (!up_clav && !dn_clav));

    assert_idle_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !up_oe |-> (up_data == '0 && !up_soc && !up_par));

    assert_start_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_now && up_en && up_clav) |=> (up_oe && up_soc));

    assert_single_soc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        up_soc |=> !up_soc);

    assert_odd_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        up_oe |-> (up_par == ~(^up_data)));

    assert_drop_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_drop_cnt != $past(dn_drop_cnt)) |-> (dn_drop_cnt == CNT_W'($past(dn_drop_cnt) + 1'b1)));

    assert_no_clav_in_cell_R10: assert property (@(posedge clk) disable iff (!rst_n)
        up_oe |-> !up_clav);
endmodule

bind utl2_slave_port utl2_slave_port_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_addr    (cfg_addr),
    .bus_addr    (bus_addr),
    .up_en       (up_en),
    .up_clav     (up_clav),
    .up_oe       (up_oe),
    .up_data     (up_data),
    .up_par      (up_par),
    .up_soc      (up_soc),
    .dn_clav     (dn_clav),
    .dn_drop_cnt (dn_drop_cnt)
);

// File: tb/test_utl2_slave_port.sv
`timescale 1ns/1ps
module test_utl2_slave_port;
    localparam int DW = 16;
    localparam int MB = 64;
    localparam int CW = 8;
    localparam int BW = $clog2(MB + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    cfg_addr = 5'd9;
    logic [BW-1:0] cfg_cell_bytes = BW'(52);
    logic          cfg_tag_en = 1'b0;
    logic [DW-1:0] cfg_tag = '0;
    logic [4:0]    bus_addr = 5'd31;
    logic          up_en = 1'b0;
    logic          up_clav, up_oe, up_par, up_soc;
    logic [DW-1:0] up_data;
    logic          dn_en = 1'b0;
    logic [DW-1:0] dn_data = '0;
    logic          dn_par = 1'b0;
    logic          dn_soc = 1'b0;
    logic          dn_clav;
    logic          core_up_valid = 1'b0;
    logic [DW-1:0] core_up_data = '0;
    logic          core_up_ready;
    logic          core_dn_valid, core_dn_last, core_dn_perr;
    logic [DW-1:0] core_dn_data;
    logic          core_dn_ready = 1'b0;
    logic [CW-1:0] dn_drop_cnt;

    utl2_slave_port #(.DATA_W(DW), .MAX_BYTES(MB), .CNT_W(CW)) i_utl2_slave_port (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_cell_bytes(cfg_cell_bytes),
        .cfg_tag_en(cfg_tag_en), .cfg_tag(cfg_tag), .bus_addr(bus_addr),
        .up_en(up_en), .up_clav(up_clav), .up_oe(up_oe), .up_data(up_data),
        .up_par(up_par), .up_soc(up_soc), .dn_en(dn_en), .dn_data(dn_data),
        .dn_par(dn_par), .dn_soc(dn_soc), .dn_clav(dn_clav),
        .core_up_valid(core_up_valid), .core_up_data(core_up_data), .core_up_ready(core_up_ready),
        .core_dn_valid(core_dn_valid), .core_dn_data(core_dn_data), .core_dn_last(core_dn_last),
        .core_dn_perr(core_dn_perr), .core_dn_ready(core_dn_ready), .dn_drop_cnt(dn_drop_cnt)
    );

    always #2.5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    logic [DW-1:0] upay [64];
    logic [DW-1:0] dpay [64];

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic opar(input logic [DW-1:0] w);
        return ~(^w);
    endfunction

    function automatic int words_of(input int bytes);
        return bytes / (DW / 8);
    endfunction

    // core loads one upstream payload
    task automatic up_push(input int n);
        for (int i = 0; i < n; i++) begin
            core_up_valid = 1'b1;
            core_up_data  = upay[i];
            while (!core_up_ready) tick();
            tick();
        end
        core_up_valid = 1'b0;
    endtask

    // master polls and reads one upstream cell
    task automatic up_pull(input int cw, input logic tag);
        bus_addr = cfg_addr;
        tick();
        check("R2", "up_clav after poll", 32'(up_clav), 32'd1);
        up_en = 1'b1;
        tick();
        up_en = 1'b0;
        bus_addr = 5'd31;
        for (int k = 0; k < cw; k++) begin
            logic [DW-1:0] exp_w;
            exp_w = (tag && k == 0) ? cfg_tag : upay[k - int'(tag)];
            check("R3", "up_oe in cell", 32'(up_oe), 32'd1);
            check("R3", "up_soc", 32'(up_soc), 32'(k == 0));
            check(tag ? "R5" : "R3", "up_data", 32'(up_data), 32'(exp_w));
            check("R4", "up_par", 32'(up_par), 32'(opar(exp_w)));
            tick();
        end
        check("R12", "up_oe after last word", 32'(up_oe), 32'd0);
        bus_addr = cfg_addr;
        tick();
        check("R10", "up_clav after cell sent", 32'(up_clav), 32'd0);
        bus_addr = 5'd31;
    endtask

    // master sends one downstream cell
    task automatic dn_push(input int cw, input logic soc_ok, input int perr_at);
        bus_addr = cfg_addr;
        tick();
        check("R2", "dn_clav after poll", 32'(dn_clav), 32'd1);
        dn_en = 1'b1;
        tick();
        dn_en = 1'b0;
        for (int k = 0; k < cw; k++) begin
            dn_data = dpay[k];
            dn_soc  = (k == 0) && soc_ok;
            dn_par  = opar(dpay[k]) ^ (k == perr_at);
            tick();
        end
        dn_data = '0;
        dn_soc  = 1'b0;
        dn_par  = 1'b0;
        bus_addr = 5'd31;
    endtask

    // core drains one downstream cell
    task automatic dn_pull(input int cw, input logic tag, input logic perr_exp);
        int np;
        np = cw - int'(tag);
        bus_addr = cfg_addr;
        tick();
        check("R10", "dn_clav while cell held", 32'(dn_clav), 32'd0);
        bus_addr = 5'd31;
        core_dn_ready = 1'b1;
        for (int k = 0; k < np; k++) begin
            check("R6", "core_dn_valid", 32'(core_dn_valid), 32'd1);
            check(tag ? "R7" : "R6", "core_dn_data", 32'(core_dn_data), 32'(dpay[k + int'(tag)]));
            check("R12", "core_dn_last", 32'(core_dn_last), 32'(k == np - 1));
            check("R9", "core_dn_perr", 32'(core_dn_perr), 32'(perr_exp));
            tick();
        end
        core_dn_ready = 1'b0;
        check("R6", "core_dn_valid after cell", 32'(core_dn_valid), 32'd0);
    endtask

    task automatic fill_rand(input int n);
        for (int i = 0; i < n; i++) begin
            upay[i] = DW'($urandom);
            dpay[i] = DW'($urandom);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cw;
        int drops_before;
        void'($urandom(32'h5eed_0123));

        // R11 reset state
        tick(); tick();
        check("R11", "up_clav in reset", 32'(up_clav), 32'd0);
        check("R11", "up_oe in reset", 32'(up_oe), 32'd0);
        rst_n = 1'b1;
        tick();
        check("R11", "core_up_ready", 32'(core_up_ready), 32'd1);
        check("R11", "dn_drop_cnt", 32'(dn_drop_cnt), 32'd0);
        check("R11", "core_dn_valid", 32'(core_dn_valid), 32'd0);
        check("R11", "dn_clav", 32'(dn_clav), 32'd0);

        // directed: 52-byte cells, no tag
        cw = words_of(52);
        fill_rand(cw);
        up_push(cw);
        // R1 foreign address with enable raised leaves the cell alone
        bus_addr = cfg_addr ^ 5'd1;
        up_en = 1'b1;
        tick();
        tick();
        check("R1", "up_oe with other address", 32'(up_oe), 32'd0);
        check("R1", "up_clav with other address", 32'(up_clav), 32'd0);
        check("R1", "up_data idle", 32'(up_data), 32'd0);
        up_en = 1'b0;
        up_pull(cw, 1'b0);
        dn_push(cw, 1'b1, -1);
        dn_pull(cw, 1'b0, 1'b0);

        // directed: 64-byte cells with routing tag
        cfg_cell_bytes = BW'(64);
        cfg_tag_en = 1'b1;
        cfg_tag = 16'hA5C3;
        cw = words_of(64);
        fill_rand(cw);
        up_push(cw - 1);
        up_pull(cw, 1'b1);
        dn_push(cw, 1'b1, -1);
        dn_pull(cw, 1'b1, 1'b0);

        // R8 missing start flag
        drops_before = int'(dn_drop_cnt);
        fill_rand(cw);
        dn_push(cw, 1'b0, -1);
        tick();
        check("R8", "core_dn_valid after drop", 32'(core_dn_valid), 32'd0);
        check("R8", "dn_drop_cnt", 32'(dn_drop_cnt), 32'(drops_before + 1));
        bus_addr = cfg_addr;
        tick();
        check("R8", "dn_clav after drop", 32'(dn_clav), 32'd1);
        bus_addr = 5'd31;

        // R9 parity error inside a cell
        cfg_tag_en = 1'b0;
        cfg_cell_bytes = BW'(20);
        cw = words_of(20);
        fill_rand(cw);
        dn_push(cw, 1'b1, 4);
        dn_pull(cw, 1'b0, 1'b1);

        // R1 idle address programmed as own address
        cfg_addr = 5'd31;
        bus_addr = 5'd31;
        tick();
        tick();
        check("R1", "dn_clav on idle address", 32'(dn_clav), 32'd0);
        dn_en = 1'b1;
        tick();
        tick();
        dn_en = 1'b0;
        check("R1", "dn capture on idle address", 32'(core_dn_valid), 32'd0);
        cfg_addr = 5'd4;
        bus_addr = 5'd31;
        tick();

        // random cells
        for (int it = 0; it < 24; it++) begin
            int   w;
            logic tg;
            int   pe;
            w  = 2 + int'($urandom % 31);
            tg = 1'($urandom % 2);
            pe = (($urandom % 4) == 0) ? int'($urandom % w) : -1;
            cfg_cell_bytes = BW'(w * 2);
            cfg_tag_en = tg;
            cfg_tag = DW'($urandom);
            fill_rand(w);
            up_push(w - int'(tg));
            up_pull(w, tg);
            dn_push(w, 1'b1, pe);
            dn_pull(w, tg, pe >= 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule